// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block gathers the interrupt conditions of a UART receiver and transmitter, masks them with a four-bit enable word and presents the most urgent one as an eight-bit identification byte in the classic 16550 encoding. It also drives one interrupt request line. The detectors that produce line errors, trigger-level hits and modem changes sit outside this block, and their outputs arrive here as levels. Two sources are built inside the block. The first is the character timeout, counted from a character-time tick. The second is a transmit-empty pending flag, which is armed by a rising edge and cleared by software actions.

Software reads the identification byte. Bit 0 low means an interrupt is pending, and bits 3:1 name the source. When the reported source is transmit-empty, the read itself acknowledges that source. Writing the transmit holding register also acknowledges it.

Top module: `uart_irq_id`

## Requirements
- R1: After synchronous reset, `iir` reads 8'hC1 and `irq` is 0.
- R2: `irq` is 1 exactly when at least one enabled source is pending, and `iir[0]` is always the inverse of `irq`.
- R3: `iir[3:1]` reports the highest-priority enabled pending source. From highest to lowest the codes are: line error 3'b011 (iir C6), data available 3'b010 (C4), character timeout 3'b110 (CC), transmit empty 3'b001 (C2), modem change 3'b000 (C0). With nothing pending, `iir` reads C1.
- R4: The enable bits map as follows: `ier[0]` enables both data available and timeout, `ier[1]` enables transmit empty, `ier[2]` enables line error and `ier[3]` enables modem change.
- R5: The timeout source asserts when `rx_nonempty` has been 1 for `TO_CHARS` (default 4) `char_tick` pulses with no `rx_activity` in between. One tick fewer leaves it deasserted.
- R6: An `rx_activity` pulse, or `rx_nonempty` going low, clears the timeout source and restarts its count from zero.
- R7: The transmit-empty flag sets in the cycle after a rising edge of `thr_empty`. Holding `thr_empty` high does not set it again once it has been cleared.
- R8: An `iir_rd` pulse clears the transmit-empty flag only while `iir[3:1]` shows 3'b001. A read while a higher source is shown leaves the flag set.
- R9: A `thr_wr` pulse clears the transmit-empty flag.
- R10: `iir[7:4]` always reads 4'b1100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier | input | 4 | Interrupt enable word |
| line_err | input | 1 | Receiver line error condition (level) |
| rx_trig | input | 1 | Receive FIFO at trigger level (level) |
| rx_nonempty | input | 1 | Receive FIFO holds at least one character |
| rx_activity | input | 1 | Receive FIFO read or write strobe |
| char_tick | input | 1 | One pulse per character time |
| thr_empty | input | 1 | Transmit holding path empty (level) |
| modem_chg | input | 1 | Modem status change condition (level) |
| iir_rd | input | 1 | Identification register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| iir | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the strobes `iir_rd`, `thr_wr`, `rx_activity` and `char_tick` are single-cycle pulses that are low during reset. They also assume that the level conditions hold steady between the clock edges that sample them. The stimulus changes every input only on the falling clock edge and lowers each strobe after one cycle. The exhaustive sweep first sets the two internal sources into a known state through their ordinary inputs, and then changes only the level inputs and the enable word, so those internal states stay where they were put.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [2:0] {
        ID_MODEM = 3'b000,
        ID_THRE  = 3'b001,
        ID_RDA   = 3'b010,
        ID_LINE  = 3'b011,
        ID_TMO   = 3'b110
    } irq_id_e;

    typedef struct packed {
        logic line;
        logic rda;
        logic tmo;
        logic thre;
        logic modem;
    } irq_src_t;

    localparam logic [3:0] ID_UPPER = 4'b1100;

    // Apply the enable word to the raw sources.
    function automatic irq_src_t mask_src(irq_src_t s, logic [3:0] en);
        irq_src_t g;
        g.rda   = s.rda   & en[0];
        g.tmo   = s.tmo   & en[0];
        g.thre  = s.thre  & en[1];
        g.line  = s.line  & en[2];
        g.modem = s.modem & en[3];
        return g;
    endfunction

    // Priority encoder over already-masked sources.
    function automatic logic [7:0] encode_id(irq_src_t g);
        irq_id_e id;
        logic    none;
        none = 1'b0;
        if (g.line)       id = ID_LINE;
        else if (g.rda)   id = ID_RDA;
        else if (g.tmo)   id = ID_TMO;
        else if (g.thre)  id = ID_THRE;
        else if (g.modem) id = ID_MODEM;
        else begin
            id   = ID_MODEM;
            none = 1'b1;
        end
        return {ID_UPPER, id, none};
    endfunction

endpackage

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
    parameter int TO_CHARS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic rx_nonempty,
    input  logic rx_activity,
    input  logic char_tick,
    output logic timeout
);
    localparam int CW = $clog2(TO_CHARS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TO_CHARS);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || rx_activity || !rx_nonempty) begin
            cnt <= '0;
        end else if (char_tick && cnt != LIMIT) begin
            cnt <= cnt + CW'(1);
        end
    end

    assign timeout = rx_nonempty && (cnt == LIMIT);

    // R6: any FIFO activity leaves the timeout deasserted next cycle
    p_activity_clears_r6: assert property (@(posedge clk) disable iff (rst)
        rx_activity |=> !timeout);

    // R5: the count never runs past its limit
    p_count_bounded_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= LIMIT);

endmodule

// File: rtl/uart_irq_txflag.sv
module uart_irq_txflag (
    input  logic clk,
    input  logic rst,
    input  logic thr_empty,
    input  logic iir_rd,
    input  logic thr_wr,
    input  logic shown_thre,
    output logic pend
);
    logic thre_q;
    logic rise;
    logic ack;

    assign rise = thr_empty & ~thre_q;
    assign ack  = thr_wr | (iir_rd & shown_thre);

    always_ff @(posedge clk) begin
        if (rst) begin
            thre_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            thre_q <= thr_empty;
            pend   <= rise | (pend & ~ack);
        end
    end

    // R9: a holding-register write with no new edge leaves the flag clear
    p_write_clears_r9: assert property (@(posedge clk) disable iff (rst)
        (thr_wr && !rise) |=> !pend);

    // R8: an acknowledging read with no new edge leaves the flag clear
    p_read_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (iir_rd && shown_thre && !rise) |=> !pend);

    // R7: without an edge the flag can only fall or hold
    p_no_rearm_r7: assert property (@(posedge clk) disable iff (rst)
        (!rise && !pend) |=> !pend);

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  irq_src_t   src,
    input  logic [3:0] ier,
    output logic [7:0] iir,
    output logic       shown_thre
);
    irq_src_t gated;

    always_comb begin
        gated      = mask_src(src, ier);
        iir        = encode_id(gated);
        shown_thre = !iir[0] && (iir[3:1] == ID_THRE);
    end

    // R3: an enabled line error always wins
    p_line_wins_r3: assert property (@(posedge clk) disable iff (rst)
        (ier[2] && src.line) |-> (iir[3:1] == ID_LINE));

    // R4: with all enables low nothing is reported
    p_mask_all_r4: assert property (@(posedge clk) disable iff (rst)
        (ier == 4'b0000) |-> iir[0]);

endmodule

// File: rtl/uart_irq_id.sv
module uart_irq_id
    import uart_irq_pkg::*;
#(
    parameter int TO_CHARS = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] ier,
    input  logic       line_err,
    input  logic       rx_trig,
    input  logic       rx_nonempty,
    input  logic       rx_activity,
    input  logic       char_tick,
    input  logic       thr_empty,
    input  logic       modem_chg,
    input  logic       iir_rd,
    input  logic       thr_wr,
    output logic [7:0] iir,
    output logic       irq
);
    logic     tmo;
    logic     thre_pend;
    logic     shown_thre;
    irq_src_t src;
    irq_src_t gated;

    uart_irq_timeout #(.TO_CHARS(TO_CHARS)) u_tmo (
        .clk         (clk),
        .rst         (rst),
        .rx_nonempty (rx_nonempty),
        .rx_activity (rx_activity),
        .char_tick   (char_tick),
        .timeout     (tmo)
    );

    uart_irq_txflag u_txf (
        .clk        (clk),
        .rst        (rst),
        .thr_empty  (thr_empty),
        .iir_rd     (iir_rd),
        .thr_wr     (thr_wr),
        .shown_thre (shown_thre),
        .pend       (thre_pend)
    );

    always_comb begin
        src.line  = line_err;
        src.rda   = rx_trig;
        src.tmo   = tmo;
        src.thre  = thre_pend;
        src.modem = modem_chg;
        gated     = mask_src(src, ier);
        irq       = |gated;
    end

    uart_irq_prio u_prio (
        .clk        (clk),
        .rst        (rst),
        .src        (src),
        .ier        (ier),
        .iir        (iir),
        .shown_thre (shown_thre)
    );

    // R2: request line and pending bit always agree
    p_irq_vs_id_r2: assert property (@(posedge clk) disable iff (rst)
        irq != iir[0]);

endmodule

// File: tb/uart_irq_id_test.sv
`timescale 1ns/1ps
module uart_irq_id_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] ier = '0;
    logic       line_err = 0, rx_trig = 0, rx_nonempty = 0, rx_activity = 0;
    logic       char_tick = 0, thr_empty = 0, modem_chg = 0, iir_rd = 0, thr_wr = 0;
    logic [7:0] iir;
    logic       irq;
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    uart_irq_id uut (
        .clk(clk), .rst(rst), .ier(ier), .line_err(line_err), .rx_trig(rx_trig),
        .rx_nonempty(rx_nonempty), .rx_activity(rx_activity), .char_tick(char_tick),
        .thr_empty(thr_empty), .modem_chg(modem_chg), .iir_rd(iir_rd), .thr_wr(thr_wr),
        .iir(iir), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] expect_id(logic l, logic d, logic t, logic e,
                                             logic m, logic [3:0] en);
        if (l && en[2]) return 8'hC6;
        if (d && en[0]) return 8'hC4;
        if (t && en[0]) return 8'hCC;
        if (e && en[1]) return 8'hC2;
        if (m && en[3]) return 8'hC0;
        return 8'hC1;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_run();
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        // R1 reset state
        chk(iir, 8'hC1, "R1 id after reset");
        chk({7'd0, irq}, 8'h00, "R1 irq after reset");
        rst = 0;
        tick();

        // Exhaustive sweep: timeout state x flag state x level sources x enables
        for (int to = 0; to < 2; to++) begin
            for (int tf = 0; tf < 2; tf++) begin
                line_err = 0; rx_trig = 0; modem_chg = 0; ier = 4'h0;
                if (to != 0) begin
                    rx_nonempty = 1;
                    for (int k = 0; k < 4; k++) begin
                        char_tick = 1; tick();
                    end
                    char_tick = 0;
                end else begin
                    rx_nonempty = 0; tick();
                end
                if (tf != 0) begin
                    thr_empty = 0; tick();
                    thr_empty = 1; tick();
                end else begin
                    thr_wr = 1; tick();
                    thr_wr = 0; tick();
                end
                for (int lv = 0; lv < 8; lv++) begin
                    for (int en = 0; en < 16; en++) begin
                        logic [7:0] e;
                        line_err  = lv[0];
                        rx_trig   = lv[1];
                        modem_chg = lv[2];
                        ier       = en[3:0];
                        tick();
                        e = expect_id(lv[0], lv[1], to[0], tf[0], lv[2], en[3:0]);
                        chk(iir, e, "R3 R4 id sweep");
                        chk({7'd0, irq}, {7'd0, ~e[0]}, "R2 irq sweep");
                        chk({iir[7:4], 4'h0}, 8'hC0, "R10 upper nibble");
                    end
                end
            end
        end

        // Timeout corner cases
        line_err = 0; rx_trig = 0; modem_chg = 0; ier = 4'b0001;
        rx_nonempty = 0; tick();
        rx_nonempty = 1;
        for (int k = 0; k < 3; k++) begin
            char_tick = 1; tick();
        end
        char_tick = 0; tick();
        chk(iir, 8'hC1, "R5 three ticks no timeout");
        char_tick = 1; tick(); char_tick = 0;
        chk(iir, 8'hCC, "R5 fourth tick timeout");
        rx_activity = 1; tick(); rx_activity = 0;
        chk(iir, 8'hC1, "R6 activity clears timeout");
        for (int k = 0; k < 3; k++) begin
            char_tick = 1; tick();
        end
        char_tick = 0;
        chk(iir, 8'hC1, "R6 count restarted");
        char_tick = 1; tick(); char_tick = 0;
        chk(iir, 8'hCC, "R6 timeout after restart");
        rx_nonempty = 0; tick();
        chk(iir, 8'hC1, "R6 empty clears timeout");

        // Transmit-empty flag
        ier = 4'b0010;
        thr_wr = 1; tick(); thr_wr = 0;
        thr_empty = 0; tick();
        thr_empty = 1; tick();
        chk(iir, 8'hC2, "R7 rise sets flag");
        iir_rd = 1; tick(); iir_rd = 0;
        chk(iir, 8'hC1, "R8 read clears when shown");
        tick(); tick();
        chk(iir, 8'hC1, "R7 held level no rearm");
        thr_empty = 0; tick();
        thr_empty = 1; tick();
        chk(iir, 8'hC2, "R7 second rise rearms");
        ier = 4'b0110; line_err = 1; tick();
        chk(iir, 8'hC6, "R3 line above thre");
        iir_rd = 1; tick(); iir_rd = 0;
        line_err = 0; tick();
        chk(iir, 8'hC2, "R8 read of other source keeps flag");
        thr_wr = 1; tick(); thr_wr = 0;
        chk(iir, 8'hC1, "R9 write clears flag");
        chk({7'd0, irq}, 8'h00, "R2 irq low when none");

        finish_run();
    end
endmodule